// File: doc/BRIEF.md
# Fixed-Level Interrupt Router with Status Register

This block collects interrupt request lines from a backplane bus, from several serial subsystems and from a temperature sensor, and presents them to a processor as six level-sensitive interrupt inputs. The top input is reserved for the floating-point unit and is passed straight through. Every other source is wired to one of the five lower inputs by a table fixed at elaboration. All sources that share a level are ORed to form that level's request. The block does not capture any source. A source keeps its line asserted until software acknowledges it at the source, and the level request falls as soon as every source on that level is quiet.

A small synchronous register port lets software inspect the raw sources of each level, one byte per level. It also gives access to a combined status/control register. A write to that register sets four LED outputs and three software-driven serial lines. The same write opens or closes the mask of the temperature interrupt, which is the only source that has a mask. A read of that register returns the raw temperature line and a bus time-out flag. Read data is registered and appears on the cycle after the read strobe.

Top module: `irq_router`

## Requirements
- R1: `cpu_int[5]` equals `fpu_irq` in the same cycle, with no masking.
- R2: For levels 0 to 4, `cpu_int[i]` is the OR, in the same cycle, of the enabled sources mapped to level i. The sources are indexed 0-6 for `bus_irq[0..6]`, 7-11 for `ser_irq[0..4]` and 12 for `temp_irq`. The default levels by index are 0,1,2,3,4,1,3,2,2,3,4,0,4.
- R3: In the cycle after a read strobe at address i (0 to 4), `rd_data` bit n holds the raw, unmasked state of the n-th source mapped to level i, counted in ascending source index. All other bits are zero.
- R4: The temperature mask is open after reset. A status write with bit 1 set opens it and a status write with bit 1 clear closes it. While the mask is closed, `temp_irq` has no effect on its level's output.
- R5: A write at address 7 loads `led[3:0]` from data bits 7..4, with `led[3]` being the leftmost LED. The same write loads `sda_o` from bit 3, `sclk_o` from bit 2 and `aclk_o` from bit 1.
- R6: Reset clears `led`, `sda_o`, `sclk_o`, `aclk_o` and `rd_data`.
- R7: In the cycle after a read at address 7, `rd_data` is {6'b0, temp_irq, bus_tmo}.
- R8: Reads at addresses 5 and 6 return zero. `rd_data` is zero in any cycle that follows a cycle without a read strobe. Writes to any address other than 7 leave the LED outputs, the serial lines and the mask unchanged.
- R9: No source is latched. A level's output drops in the same cycle that the last asserted source on that level is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_irq | input | 7 | Backplane bus interrupt requests 1..7 (bit 0 = request 1) |
| ser_irq | input | 5 | Serial subsystem interrupt requests |
| temp_irq | input | 1 | Temperature interrupt request, maskable |
| fpu_irq | input | 1 | Floating-point interrupt request |
| bus_tmo | input | 1 | Bus time-out flag, readable in the status register |
| addr | input | 3 | Register address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Registered read data |
| cpu_int | output | 6 | Processor interrupt levels, bit 5 highest |
| led | output | 4 | LED drive, bit 3 leftmost |
| sda_o | output | 1 | Serial data line |
| sclk_o | output | 1 | Serial clock line |
| aclk_o | output | 1 | Auxiliary serial clock line |

## Verification
The assertions assume that every input is synchronous to `clk` and settles before the rising edge. They also assume that the strobes and the address are never unknown once reset is released, because the write and read-data properties sample them at each edge. The bench drives all inputs on the falling edge and keeps them at defined values at all times, including during reset. It checks the combinational interrupt outputs a short delay after each change, and it checks the registered read data on the falling edge after the strobe.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int NUM_BUS  = 7;
    localparam int NUM_SER  = 5;
    localparam int NUM_SRC  = NUM_BUS + NUM_SER + 1;
    localparam int NUM_LVL  = 5;
    localparam int LVL_W    = 3;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 3;

    // Level per source, highest index first: temp, ser4..ser0, bus6..bus0
    localparam logic [NUM_SRC*LVL_W-1:0] DEFAULT_MAP = {
        3'd4,
        3'd0, 3'd4, 3'd3, 3'd2, 3'd2,
        3'd3, 3'd1, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0
    };

    typedef enum logic [1:0] {
        SEL_IDLE,
        SEL_LEVEL,
        SEL_STATUS,
        SEL_EMPTY
    } rd_sel_e;

    typedef struct packed {
        logic [3:0] led;
        logic       sda;
        logic       sclk;
        logic       aclk;
    } line_regs_t;

endpackage

// File: rtl/irq_level_map.sv
module irq_level_map #(
    parameter int NSRC   = 13,
    parameter int NLVL   = 5,
    parameter int LVL_W  = 3,
    parameter int DATA_W = 8,
    parameter logic [NSRC*LVL_W-1:0] MAP = '0
) (
    input  logic [NSRC-1:0]        src_raw,
    input  logic [NSRC-1:0]        src_en,
    output logic [NLVL-1:0]        lvl_req,
    output logic [NLVL*DATA_W-1:0] lvl_view
);

    localparam int POS_W = $clog2(DATA_W) + 1;

    for (genvar lv = 0; lv < NLVL; lv++) begin : g_lvl
        logic              req;
        logic [DATA_W-1:0] view;
        logic [POS_W-1:0]  pos;

        always_comb begin
            req  = 1'b0;
            view = '0;
            pos  = '0;
            for (int s = 0; s < NSRC; s++) begin
                if (MAP[s*LVL_W +: LVL_W] == LVL_W'(lv)) begin
                    req = req | (src_raw[s] & src_en[s]);
                    if (pos < POS_W'(DATA_W)) begin
                        view[pos[POS_W-2:0]] = src_raw[s];
                    end
                    pos = pos + 1'b1;
                end
            end
        end

        assign lvl_req[lv]                    = req;
        assign lvl_view[lv*DATA_W +: DATA_W]  = view;
    end

endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
    import irq_router_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    output line_regs_t        lines,
    output logic              temp_open
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lines     <= '0;
            temp_open <= 1'b1;
        end else if (wr_stb) begin
            lines.led  <= wr_data[7:4];
            lines.sda  <= wr_data[3];
            lines.sclk <= wr_data[2];
            lines.aclk <= wr_data[1];
            temp_open  <= wr_data[1];
        end
    end

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NBUS   = NUM_BUS,
    parameter int NSER   = NUM_SER,
    parameter int NLVL   = NUM_LVL,
    parameter int LVL_W  = irq_router_pkg::LVL_W,
    parameter int DATA_W = irq_router_pkg::DATA_W,
    parameter int ADDR_W = irq_router_pkg::ADDR_W,
    parameter logic [(NBUS+NSER+1)*LVL_W-1:0] SRC_MAP = DEFAULT_MAP,
    parameter logic [ADDR_W-1:0] STAT_ADDR = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NBUS-1:0]   bus_irq,
    input  logic [NSER-1:0]   ser_irq,
    input  logic              temp_irq,
    input  logic              fpu_irq,
    input  logic              bus_tmo,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [NLVL:0]     cpu_int,
    output logic [3:0]        led,
    output logic              sda_o,
    output logic              sclk_o,
    output logic              aclk_o
);

    localparam int NSRC = NBUS + NSER + 1;

    logic [NSRC-1:0]        src_raw;
    logic [NSRC-1:0]        src_en;
    logic [NLVL-1:0]        lvl_req;
    logic [NLVL*DATA_W-1:0] lvl_view;
    logic                   temp_open;
    line_regs_t             lines;
    rd_sel_e                rd_sel;
    logic [DATA_W-1:0]      rd_next;
    int                     lvl_idx;

    assign src_raw = {temp_irq, ser_irq, bus_irq};
    assign src_en  = {temp_open, {(NSRC-1){1'b1}}};

    irq_level_map #(
        .NSRC   (NSRC),
        .NLVL   (NLVL),
        .LVL_W  (LVL_W),
        .DATA_W (DATA_W),
        .MAP    (SRC_MAP)
    ) u_map (
        .src_raw  (src_raw),
        .src_en   (src_en),
        .lvl_req  (lvl_req),
        .lvl_view (lvl_view)
    );

    irq_status_reg #(
        .DATA_W (DATA_W)
    ) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_en && (addr == STAT_ADDR)),
        .wr_data   (wr_data),
        .lines     (lines),
        .temp_open (temp_open)
    );

    assign cpu_int = {fpu_irq, lvl_req};
    assign led     = lines.led;
    assign sda_o   = lines.sda;
    assign sclk_o  = lines.sclk;
    assign aclk_o  = lines.aclk;

    // Read source selection
    always_comb begin
        if (!rd_en)
            rd_sel = SEL_IDLE;
        else if (addr == STAT_ADDR)
            rd_sel = SEL_STATUS;
        else if (int'(addr) < NLVL)
            rd_sel = SEL_LEVEL;
        else
            rd_sel = SEL_EMPTY;
    end

    assign lvl_idx = (int'(addr) < NLVL) ? int'(addr) : 0;

    always_comb begin
        rd_next = '0;
        unique case (rd_sel)
            SEL_IDLE:   rd_next = '0;
            SEL_LEVEL:  rd_next = lvl_view[lvl_idx*DATA_W +: DATA_W];
            SEL_STATUS: rd_next = {{(DATA_W-2){1'b0}}, temp_irq, bus_tmo};
            SEL_EMPTY:  rd_next = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rd_data <= '0;
        else
            rd_data <= rd_next;
    end

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [6:0] bus_irq,
    input logic [4:0] ser_irq,
    input logic       temp_irq,
    input logic       fpu_irq,
    input logic [2:0] addr,
    input logic       rd_en,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic [5:0] cpu_int,
    input logic [3:0] led,
    input logic       sda_o,
    input logic       sclk_o,
    input logic       aclk_o
);

    assert_fpu_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_int[5] == fpu_irq);

    assert_bus0_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_irq[0] |-> cpu_int[0]);

    assert_quiet_levels_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_irq == '0 && ser_irq == '0 && !temp_irq) |-> (cpu_int[4:0] == '0));

    assert_status_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd7) |=>
        ({led, sda_o, sclk_o, aclk_o} == $past(wr_data[7:1])));

    assert_lines_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == 3'd7) |=> $stable({led, sda_o, sclk_o, aclk_o}));

    assert_idle_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rd_data == '0));

    assert_status_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 3'd7) |=> (rd_data[7:2] == '0));

endmodule

bind irq_router irq_router_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_irq  (bus_irq),
    .ser_irq  (ser_irq),
    .temp_irq (temp_irq),
    .fpu_irq  (fpu_irq),
    .addr     (addr),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .cpu_int  (cpu_int),
    .led      (led),
    .sda_o    (sda_o),
    .sclk_o   (sclk_o),
    .aclk_o   (aclk_o)
);

// File: tb/tb_irq_router.sv
`timescale 1ns/1ps
module tb_irq_router;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [6:0] bus_irq;
    logic [4:0] ser_irq;
    logic       temp_irq, fpu_irq, bus_tmo;
    logic [2:0] addr;
    logic       rd_en, wr_en;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic [5:0] cpu_int;
    logic [3:0] led;
    logic       sda_o, sclk_o, aclk_o;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 0;
    bit  m_open;
    int  lvl_of [13] = '{0,1,2,3,4,1,3,2,2,3,4,0,4};

    always #2.5 clk = ~clk;

    irq_router dut (
        .clk(clk), .rst_n(rst_n), .bus_irq(bus_irq), .ser_irq(ser_irq),
        .temp_irq(temp_irq), .fpu_irq(fpu_irq), .bus_tmo(bus_tmo),
        .addr(addr), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .cpu_int(cpu_int), .led(led), .sda_o(sda_o),
        .sclk_o(sclk_o), .aclk_o(aclk_o)
    );

    function automatic logic [12:0] srcs();
        return {temp_irq, ser_irq, bus_irq};
    endfunction

    function automatic logic [5:0] exp_int();
        logic [5:0] r = '0;
        logic [12:0] s = srcs();
        for (int i = 0; i < 13; i++)
            if (s[i] && (i != 12 || m_open)) r[lvl_of[i]] = 1'b1;
        r[5] = fpu_irq;
        return r;
    endfunction

    function automatic logic [7:0] exp_rd(input logic [2:0] a);
        logic [7:0] r = '0;
        int n = 0;
        logic [12:0] s = srcs();
        if (a == 3'd7) return {6'b0, temp_irq, bus_tmo};
        if (a > 3'd4) return 8'h00;
        for (int i = 0; i < 13; i++)
            if (lvl_of[i] == int'(a)) begin
                r[n] = s[i];
                n++;
            end
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        if (a == 3'd7) m_open = d[1];
        #1;
    endtask

    task automatic do_rd(input logic [2:0] a, input string req);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        chk(req, rd_data, exp_rd(a));
        rd_en = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst_n = 1'b0; bus_irq = '0; ser_irq = '0; temp_irq = 0; fpu_irq = 0;
        bus_tmo = 0; addr = '0; rd_en = 0; wr_en = 0; wr_data = '0;
        m_open = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R6 lines", {led, sda_o, sclk_o, aclk_o}, 7'h00);
        chk("R6 rd_data", rd_data, 8'h00);
        rst_n = 1'b1;
        #1;
        chk("R9 quiet", cpu_int, 6'h00);

        // R4 open after reset
        temp_irq = 1'b1; #1;
        chk("R4 open at reset", cpu_int, 6'h10);
        temp_irq = 1'b0;

        // R2 / R3 each source alone
        for (int s = 0; s < 13; s++) begin
            @(negedge clk);
            {temp_irq, ser_irq, bus_irq} = 13'b1 << s;
            #1;
            chk("R2 mapping", cpu_int, exp_int());
            do_rd(3'(lvl_of[s]), "R3 level view");
        end
        {temp_irq, ser_irq, bus_irq} = '0;

        fpu_irq = 1'b1; #1;
        chk("R1 fpu", cpu_int, 6'h20);
        fpu_irq = 1'b0;

        // R5 and R4 close
        do_wr(3'd7, 8'b1010_1100);
        chk("R5 lines", {led, sda_o, sclk_o, aclk_o}, 7'b1010_110);
        temp_irq = 1'b1; #1;
        chk("R4 masked", cpu_int, 6'h00);
        do_rd(3'd4, "R3 raw temp");
        bus_tmo = 1'b1;
        do_rd(3'd7, "R7 status");
        bus_tmo = 1'b0;
        do_wr(3'd7, 8'h02);
        chk("R4 reopened", cpu_int, 6'h10);
        temp_irq = 1'b0;

        // R8
        do_wr(3'd3, 8'hF0);
        chk("R8 other write", {led, sda_o, sclk_o, aclk_o}, 7'b0000_001);
        temp_irq = 1'b1; #1;
        chk("R8 mask kept", cpu_int, 6'h10);
        temp_irq = 1'b0;
        ser_irq = 5'h1F; bus_irq = 7'h7F;
        do_rd(3'd5, "R8 addr5");
        do_rd(3'd6, "R8 addr6");
        @(negedge clk);
        chk("R8 idle rd", rd_data, 8'h00);
        ser_irq = '0; bus_irq = '0;

        // R9 release
        ser_irq = 5'b00011; #1;
        chk("R9 two on level2", cpu_int, 6'h04);
        ser_irq = 5'b00010; #1;
        chk("R9 one left", cpu_int, 6'h04);
        ser_irq = 5'b00000; #1;
        chk("R9 released", cpu_int, 6'h00);

        // random
        for (int it = 0; it < 400; it++) begin
            @(negedge clk);
            bus_irq  = 7'($urandom() & $urandom());
            ser_irq  = 5'($urandom() & $urandom());
            temp_irq = 1'($urandom());
            fpu_irq  = 1'($urandom());
            bus_tmo  = 1'($urandom());
            #1;
            chk("R2 random", cpu_int, exp_int());
            case ($urandom() % 3)
                0: do_rd(3'($urandom()), "R3 random read");
                1: begin
                    do_wr(3'(($urandom() % 2) ? 7 : ($urandom() % 7)), 8'($urandom()));
                    chk("R4 random", cpu_int, exp_int());
                end
                default: ;
            endcase
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule